// File: doc/BRIEF.md
# Asynchronous SRAM Sequencer

This block sits between a synchronous request port and an external asynchronous static RAM that is 16 bits wide, has 18 address bits and two byte lanes. Each accepted request makes one device cycle. A read or a write can be limited to either byte lane. The RAM's strobes are all active low: chip select, output enable, write enable and one enable per byte lane. The block drives them from registers, and the length of every phase is a whole number of clock cycles set by a parameter.

Writes are ended by write enable, and output enable stays low for the whole selected period. When write enable falls, the RAM may still be driving the bus. The sequencer therefore keeps its own data driver off for a number of turnaround cycles. It then drives the data for the rest of the write pulse, and keeps driving for one more cycle after write enable and chip select have both risen, so the data hold time is met. A request whose byte mask is empty makes no device cycle at all.

Top module: `sram16_ctrl`

## Requirements
- R1: During reset and afterwards while idle: chip select, output enable and write enable are high, both byte enables are high, the data driver is off, `req_ready` is 1 and `rsp_valid` is 0.
- R2: A read holds chip select low, output enable low and write enable high for exactly RD_CYC cycles. Throughout the read, `ram_be_n` is the inverse of `req_mask`. Bit 0 is the lower byte (data bits 7:0) and bit 1 is the upper byte (bits 15:8).
- R3: Read data is sampled on the clock edge that ends the read wait. `rsp_valid` is high for the following cycle, with `rsp_rdata` holding the enabled lanes and zero in each lane whose mask bit is 0.
- R4: A write holds write enable low for exactly TURN_CYC + WE_CYC consecutive cycles, with chip select and output enable low throughout. Write enable is never low while chip select is high.
- R5: During the first TURN_CYC cycles of write enable low, the data driver is off. It is on for the remaining WE_CYC cycles.
- R6: In the cycle after write enable rises, chip select is high and the driver still presents the same write data. In the cycle after that, the driver is off.
- R7: Address and byte enables do not change while chip select stays low.
- R8: `req_ready` is low from the accepting edge until the sequencer is idle again. That is TURN_CYC + WE_CYC + 1 cycles for a write and RD_CYC cycles for a read. Whenever `req_ready` is high, chip select is high and the driver is off.
- R9: A request with `req_mask` = 0 never pulls chip select low, and `req_ready` stays high. For such a read, `rsp_valid` pulses in the next cycle with `rsp_rdata` = 0.
- R10: A new request is accepted on the first edge at which `req_ready` is high again.
- R11: A write with one mask bit clear leaves that byte of the addressed word unchanged in the RAM.
- R12: The data driver is never on while the RAM may be driving the bus (chip select low, output enable low, write enable high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Byte lanes to access, active high, bit 0 = bits 7:0 |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| ram_addr | output | 18 | RAM address |
| ram_ce_n | output | 1 | RAM chip select, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_we_n | output | 1 | RAM write enable, active low |
| ram_be_n | output | 2 | RAM byte enables, active low, bit 0 = lower byte |
| ram_dq_out | output | 16 | Data to the pad driver |
| ram_dq_oe | output | 1 | Pad driver enable |
| ram_dq_in | input | 16 | Data from the pad receiver |

## Verification
A behavioural RAM model in the bench commits a write only when the overlap of chip select and write enable ends, and stores whatever the driver presents at that moment. It answers reads with junk on the lanes that are not enabled. Random reads and writes with all four mask values go to a small address window, so read data is compared against a bench shadow memory. A masked read that shows junk shows that lane zeroing is broken. A write followed by a read that comes back wrong shows a bad drive window or a bad lane commit. Directed cases cover the top and bottom addresses, a single-lane write over a known word (R11), empty masks on both directions, and back-to-back requests. These separate a wrong phase length from wrong lane handling.

// File: rtl/sram16_pkg.sv
// Package: shared state type and strobe decode for the SRAM sequencer.
// Assumes all RAM strobes are active low and the pad driver enable is active high.
package sram16_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_RD_WAIT  = 3'd1,
        ST_WR_TURN  = 3'd2,
        ST_WR_DRIVE = 3'd3,
        ST_WR_HOLD  = 3'd4
    } seq_state_t;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic drv;
    } strobe_t;

    // Strobe levels that belong to each sequencer state.
    function automatic strobe_t strobes_for(seq_state_t s);
        strobe_t r;
        unique case (s)
            ST_RD_WAIT:  r = '{ce_n: 1'b0, oe_n: 1'b0, we_n: 1'b1, drv: 1'b0};
            ST_WR_TURN:  r = '{ce_n: 1'b0, oe_n: 1'b0, we_n: 1'b0, drv: 1'b0};
            ST_WR_DRIVE: r = '{ce_n: 1'b0, oe_n: 1'b0, we_n: 1'b0, drv: 1'b1};
            ST_WR_HOLD:  r = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, drv: 1'b1};
            default:     r = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, drv: 1'b0};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sram16_timer.sv
// Phase timer: loads a count of (cycles - 1) and counts down to zero.
// Assumes the loaded value fits CNT_W bits; 'expired' is high while the count is zero.
module sram16_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    // Load on phase entry, otherwise count down and stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram16_seq.sv
// Phase sequencer: walks read and write device cycles and registers the RAM strobes.
// Assumes WE_CYC >= 1 and RD_CYC >= 1; TURN_CYC may be 0, in which case the turnaround phase is skipped.
module sram16_seq
    import sram16_pkg::*;
#(
    parameter int WE_CYC   = 1,
    parameter int RD_CYC   = 2,
    parameter int TURN_CYC = 1,
    parameter int CNT_W    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             start_wr,
    input  logic             tmr_expired,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output seq_state_t       state_q,
    output logic             going_idle,
    output logic             rd_capture,
    output strobe_t          strb_q
);

    localparam logic [CNT_W-1:0] WE_LD   = CNT_W'(WE_CYC - 1);
    localparam logic [CNT_W-1:0] RD_LD   = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] TURN_LD = CNT_W'((TURN_CYC > 0) ? TURN_CYC - 1 : 0);
    localparam bit               HAS_TURN = (TURN_CYC > 0);

    seq_state_t state_nxt;

    // Next-state and timer-load decode.
    always_comb begin
        state_nxt = state_q;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    tmr_load = 1'b1;
                    if (!start_wr) begin
                        state_nxt = ST_RD_WAIT;
                        tmr_val   = RD_LD;
                    end else if (HAS_TURN) begin
                        state_nxt = ST_WR_TURN;
                        tmr_val   = TURN_LD;
                    end else begin
                        state_nxt = ST_WR_DRIVE;
                        tmr_val   = WE_LD;
                    end
                end
            end
            ST_RD_WAIT: begin
                if (tmr_expired) state_nxt = ST_IDLE;
            end
            ST_WR_TURN: begin
                if (tmr_expired) begin
                    state_nxt = ST_WR_DRIVE;
                    tmr_load  = 1'b1;
                    tmr_val   = WE_LD;
                end
            end
            ST_WR_DRIVE: begin
                if (tmr_expired) state_nxt = ST_WR_HOLD;
            end
            ST_WR_HOLD: begin
                state_nxt = ST_IDLE;
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // State register and registered strobes, so no decode glitch reaches the pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            strb_q  <= strobes_for(ST_IDLE);
        end else begin
            state_q <= state_nxt;
            strb_q  <= strobes_for(state_nxt);
        end
    end

    assign going_idle = (state_q != ST_IDLE) && (state_nxt == ST_IDLE);
    assign rd_capture = (state_q == ST_RD_WAIT) && tmr_expired;

endmodule

// File: rtl/sram16_rdcap.sv
// Read capture: samples the pad receiver per byte lane and zeroes lanes that were not requested.
// Assumes 'capture' and 'blank' are never high in the same cycle.
module sram16_rdcap #(
    parameter int LANES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               capture,
    input  logic               blank,
    input  logic [LANES-1:0]   lane_mask,
    input  logic [8*LANES-1:0] dq_in,
    output logic               rsp_valid,
    output logic [8*LANES-1:0] rsp_rdata
);

    // One-cycle response strobe for captured or empty reads.
    always_ff @(posedge clk) begin
        if (!rst_n) rsp_valid <= 1'b0;
        else        rsp_valid <= capture | blank;
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        // Per-lane data register: requested lanes take the bus, others read as zero.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rsp_rdata[8*l +: 8] <= '0;
            end else if (capture) begin
                rsp_rdata[8*l +: 8] <= lane_mask[l] ? dq_in[8*l +: 8] : 8'h00;
            end else if (blank) begin
                rsp_rdata[8*l +: 8] <= 8'h00;
            end
        end
    end

endmodule

// File: rtl/sram16_ctrl.sv
// Top: single-word request port to an asynchronous byte-lane SRAM.
// Assumes the pad ring turns ram_dq_out/ram_dq_oe/ram_dq_in into one tri-state bus
// and that all phase lengths, given in clock cycles, meet the RAM's timing at the clock used.
module sram16_ctrl
    import sram16_pkg::*;
#(
    parameter int ADDR_W   = 18,
    parameter int LANES    = 2,
    parameter int WE_CYC   = 1,
    parameter int RD_CYC   = 2,
    parameter int TURN_CYC = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [8*LANES-1:0] req_wdata,
    input  logic [LANES-1:0]   req_mask,
    output logic               rsp_valid,
    output logic [8*LANES-1:0] rsp_rdata,
    output logic [ADDR_W-1:0]  ram_addr,
    output logic               ram_ce_n,
    output logic               ram_oe_n,
    output logic               ram_we_n,
    output logic [LANES-1:0]   ram_be_n,
    output logic [8*LANES-1:0] ram_dq_out,
    output logic               ram_dq_oe,
    input  logic [8*LANES-1:0] ram_dq_in
);

    localparam int DATA_W  = 8 * LANES;
    localparam int MAX_A   = (WE_CYC > RD_CYC) ? WE_CYC : RD_CYC;
    localparam int MAX_CYC = (MAX_A > TURN_CYC) ? MAX_A : TURN_CYC;
    localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

    seq_state_t        state_q;
    strobe_t           strb_q;
    logic              accept, empty_req, start, blank_rd;
    logic              tmr_load, tmr_expired, going_idle, rd_capture;
    logic [CNT_W-1:0]  tmr_val;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [LANES-1:0]  mask_q;
    logic [LANES-1:0]  be_n_q;

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign empty_req = (req_mask == '0);
    assign start     = accept && !empty_req;
    assign blank_rd  = accept && empty_req && !req_write;

    // Request registers: latched on a real start, byte enables released on return to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            mask_q  <= '0;
            be_n_q  <= '1;
        end else if (start) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            mask_q  <= req_mask;
            be_n_q  <= ~req_mask;
        end else if (going_idle) begin
            be_n_q  <= '1;
        end
    end

    sram16_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    sram16_seq #(
        .WE_CYC   (WE_CYC),
        .RD_CYC   (RD_CYC),
        .TURN_CYC (TURN_CYC),
        .CNT_W    (CNT_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .start_wr    (req_write),
        .tmr_expired (tmr_expired),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .state_q     (state_q),
        .going_idle  (going_idle),
        .rd_capture  (rd_capture),
        .strb_q      (strb_q)
    );

    sram16_rdcap #(
        .LANES (LANES)
    ) u_rdcap (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (rd_capture),
        .blank     (blank_rd),
        .lane_mask (mask_q),
        .dq_in     (ram_dq_in),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    assign ram_addr   = addr_q;
    assign ram_ce_n   = strb_q.ce_n;
    assign ram_oe_n   = strb_q.oe_n;
    assign ram_we_n   = strb_q.we_n;
    assign ram_dq_oe  = strb_q.drv;
    assign ram_be_n   = be_n_q;
    assign ram_dq_out = wdata_q;

endmodule

// File: rtl/sram16_ctrl_chk.sv
// Checker: protocol properties on the RAM-side pins of sram16_ctrl, attached by bind.
// Assumes the same parameters as the bound instance.
module sram16_ctrl_chk #(
    parameter int ADDR_W   = 18,
    parameter int LANES    = 2,
    parameter int TURN_CYC = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic [ADDR_W-1:0] ram_addr,
    input logic              ram_ce_n,
    input logic              ram_oe_n,
    input logic              ram_we_n,
    input logic [LANES-1:0]  ram_be_n,
    input logic              ram_dq_oe
);

    AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (ram_ce_n && !ram_dq_oe)); // R8

    AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
        (!ram_ce_n && !ram_oe_n && ram_we_n) |-> !ram_dq_oe); // R12

    AST_WE_INSIDE_CE: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_we_n |-> (!ram_ce_n && !ram_oe_n)); // R4

    AST_READ_OE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!ram_ce_n && ram_we_n) |-> !ram_oe_n); // R2

    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ram_we_n) |-> (ram_dq_oe && ram_ce_n)); // R6

    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ram_ce_n && $past(!ram_ce_n)) |-> ($stable(ram_addr) && $stable(ram_be_n))); // R7

    if (TURN_CYC > 0) begin : g_turn
        AST_TURN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(ram_we_n) |-> !ram_dq_oe); // R5
    end

endmodule

bind sram16_ctrl sram16_ctrl_chk #(
    .ADDR_W   (ADDR_W),
    .LANES    (LANES),
    .TURN_CYC (TURN_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .ram_addr  (ram_addr),
    .ram_ce_n  (ram_ce_n),
    .ram_oe_n  (ram_oe_n),
    .ram_we_n  (ram_we_n),
    .ram_be_n  (ram_be_n),
    .ram_dq_oe (ram_dq_oe)
);

// File: tb/sram16_ctrl_test.sv
// Bench: random and directed requests against a behavioural asynchronous RAM model.
module sram16_ctrl_test;

    localparam int TURN = 1;
    localparam int WEC  = 1;
    localparam int RDC  = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic        req_ready;
    logic [17:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_mask = '0;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic [17:0] ram_addr;
    logic        ram_ce_n, ram_oe_n, ram_we_n, ram_dq_oe;
    logic [1:0]  ram_be_n;
    logic [15:0] ram_dq_out;
    logic [15:0] ram_dq_in = 16'hDEAD;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    sram16_ctrl #(
        .ADDR_W(18), .LANES(2), .WE_CYC(WEC), .RD_CYC(RDC), .TURN_CYC(TURN)
    ) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_mask(req_mask), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .ram_addr(ram_addr), .ram_ce_n(ram_ce_n), .ram_oe_n(ram_oe_n),
        .ram_we_n(ram_we_n), .ram_be_n(ram_be_n), .ram_dq_out(ram_dq_out),
        .ram_dq_oe(ram_dq_oe), .ram_dq_in(ram_dq_in)
    );

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    // Expected read value: requested lanes from the shadow, others zero.
    function automatic logic [15:0] exp_read(input logic [15:0] word, input logic [1:0] m);
        return {m[1] ? word[15:8] : 8'h00, m[0] ? word[7:0] : 8'h00};
    endfunction

    function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] d, input logic [1:0] m);
        return {m[1] ? d[15:8] : old[15:8], m[0] ? d[7:0] : old[7:0]};
    endfunction

    // ---------------- behavioural RAM model ----------------
    logic [15:0] ram_mem [int];
    logic [15:0] shadow  [int];
    bit          wr_prev = 1'b0;
    logic [17:0] pend_addr;
    logic [15:0] pend_data;
    logic [1:0]  pend_be;

    always @(negedge clk) begin
        logic [15:0] w;
        if (!ram_ce_n && !ram_we_n) begin
            pend_addr = ram_addr;
            pend_be   = ram_be_n;
            pend_data = ram_dq_oe ? ram_dq_out : 16'hxxxx;
            wr_prev   = 1'b1;
        end else if (wr_prev) begin
            w = ram_mem.exists(int'(pend_addr)) ? ram_mem[int'(pend_addr)] : 16'h0000;
            if (!pend_be[0]) w[7:0]  = pend_data[7:0];
            if (!pend_be[1]) w[15:8] = pend_data[15:8];
            ram_mem[int'(pend_addr)] = w;
            wr_prev = 1'b0;
        end
        if (!ram_ce_n && !ram_oe_n && ram_we_n) begin
            w = ram_mem.exists(int'(ram_addr)) ? ram_mem[int'(ram_addr)] : 16'h0000;
            ram_dq_in <= {ram_be_n[1] ? 8'hC3 : w[15:8], ram_be_n[0] ? 8'h3C : w[7:0]};
        end else begin
            ram_dq_in <= 16'hDEAD;
        end
    end

    // ---------------- strobe monitor ----------------
    logic [1:0]  cur_mask = '0;
    logic [15:0] cur_data = '0;
    int          we_low = 0, rd_low = 0, ce_low_cnt = 0;
    bit          hold_pend = 1'b0;
    logic        prev_ce_n = 1'b1;
    logic [17:0] prev_addr = '0;
    logic [1:0]  prev_be = 2'b11;

    always @(posedge clk) if (rst_n && !ram_ce_n) ce_low_cnt++;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!ram_we_n) begin
                chk(ram_dq_oe === (we_low >= TURN), "R5 driver vs write-enable-low index", 32'(ram_dq_oe), 32'(we_low >= TURN));
                chk(!ram_ce_n && !ram_oe_n, "R4 select and output enable low in write", {30'd0, ram_ce_n, ram_oe_n}, 32'd0);
                we_low++;
            end else if (we_low != 0) begin
                chk(we_low == TURN + WEC, "R4 write-enable-low length", 32'(we_low), 32'(TURN + WEC));
                chk(ram_ce_n && ram_dq_oe && ram_dq_out === cur_data, "R6 hold cycle", {ram_ce_n, ram_dq_oe, ram_dq_out}, {2'b11, cur_data});
                we_low = 0;
                hold_pend = 1'b1;
            end else if (hold_pend) begin
                chk(!ram_dq_oe, "R6 driver released", 32'(ram_dq_oe), 32'd0);
                hold_pend = 1'b0;
            end
            if (!ram_ce_n && ram_we_n) begin
                rd_low++;
                chk(!ram_oe_n && ram_be_n == ~cur_mask, "R2 read strobes and lanes", {ram_oe_n, ram_be_n}, {1'b0, ~cur_mask});
                chk(!ram_dq_oe, "R12 no drive while RAM drives", 32'(ram_dq_oe), 32'd0);
            end else if (ram_ce_n && rd_low != 0) begin
                chk(rd_low == RDC, "R2 read length", 32'(rd_low), 32'(RDC));
                rd_low = 0;
            end
            if (!ram_ce_n && !prev_ce_n)
                chk(ram_addr == prev_addr && ram_be_n == prev_be, "R7 address and lanes stable", {ram_be_n, ram_addr}, {prev_be, prev_addr});
            prev_ce_n = ram_ce_n;
            prev_addr = ram_addr;
            prev_be   = ram_be_n;
        end
    end

    // ---------------- request driver ----------------
    task automatic do_op(input bit wr, input logic [17:0] a, input logic [15:0] d, input logic [1:0] m, input string tag);
        int low = 0;
        int ce_before;
        int exp_low;
        logic [15:0] old;
        chk(req_ready === 1'b1, "R10 ready for next request", 32'(req_ready), 32'd1);
        old = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0000;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
        if (m != 2'b00) begin cur_mask = m; cur_data = d; end
        ce_before = ce_low_cnt;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (!req_ready && low < 50) begin
            low++;
            @(negedge clk);
        end
        exp_low = (m == 2'b00) ? 0 : (wr ? TURN + WEC + 1 : RDC);
        chk(low == exp_low, "R8 ready-low cycles", 32'(low), 32'(exp_low));
        if (m == 2'b00)
            chk(ce_low_cnt == ce_before, "R9 empty mask makes no device cycle", 32'(ce_low_cnt - ce_before), 32'd0);
        if (!wr) begin
            chk(rsp_valid === 1'b1 && rsp_rdata === exp_read(old, m), tag, {15'd0, rsp_valid, rsp_rdata}, {15'd0, 1'b1, exp_read(old, m)});
        end else begin
            chk(rsp_valid === 1'b0, "R3 no response to a write", 32'(rsp_valid), 32'd0);
            shadow[int'(a)] = merge(old, d, m);
        end
    endtask

    // ---------------- main sequence ----------------
    initial begin
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        chk(ram_ce_n && ram_oe_n && ram_we_n && !ram_dq_oe && ram_be_n == 2'b11 && req_ready && !rsp_valid,
            "R1 reset state", {25'd0, ram_ce_n, ram_oe_n, ram_we_n, ram_dq_oe, ram_be_n, req_ready}, 32'b1110111);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(ram_ce_n && ram_we_n && !ram_dq_oe && req_ready && !rsp_valid, "R1 idle after reset",
            {27'd0, ram_ce_n, ram_we_n, ram_dq_oe, req_ready, rsp_valid}, 32'b11010);

        do_op(1'b1, 18'h00000, 16'hA55A, 2'b11, "R3 write low edge");
        do_op(1'b1, 18'h3FFFF, 16'h1357, 2'b11, "R3 write high edge");
        do_op(1'b0, 18'h00000, 16'h0000, 2'b11, "R3 read lowest address");
        do_op(1'b0, 18'h3FFFF, 16'h0000, 2'b11, "R3 read highest address");
        do_op(1'b1, 18'h00005, 16'h1234, 2'b11, "R11 setup");
        do_op(1'b1, 18'h00005, 16'hABCD, 2'b01, "R11 lower-only write");
        do_op(1'b0, 18'h00005, 16'h0000, 2'b11, "R11 upper byte kept");
        do_op(1'b1, 18'h00005, 16'h7788, 2'b10, "R11 upper-only write");
        do_op(1'b0, 18'h00005, 16'h0000, 2'b11, "R11 lower byte kept");
        do_op(1'b0, 18'h00005, 16'h0000, 2'b01, "R3 lower lane read, upper zero");
        do_op(1'b0, 18'h00005, 16'h0000, 2'b10, "R3 upper lane read, lower zero");
        do_op(1'b1, 18'h00005, 16'hFFFF, 2'b00, "R9 empty write");
        do_op(1'b0, 18'h00005, 16'h0000, 2'b11, "R9 empty write left word");
        do_op(1'b0, 18'h00005, 16'h0000, 2'b00, "R9 empty read returns zero");
        do_op(1'b0, 18'h00006, 16'h0000, 2'b00, "R9 second empty read back to back");

        for (int i = 0; i < 400; i++) begin
            logic [17:0] a;
            logic [1:0]  m;
            bit          wr;
            a  = ($urandom % 10 == 0) ? 18'h3FFFF : 18'($urandom % 8);
            m  = 2'($urandom);
            wr = 1'($urandom);
            do_op(wr, a, 16'($urandom), m, "R3 random read");
        end

        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule